// File: doc/BRIEF.md
# UART Transmitter Register Front End

This block sits on a simple synchronous memory-mapped bus and gives software control of a serial transmit engine that lives outside it. Software loads the byte to send into a data register. It sets the bit rate, the parity enable and the number of stop bits through configuration registers. It can poll a sampled copy of the engine's busy flag. The configuration registers drive the engine's inputs directly. A write of a byte fires a one-cycle start pulse to the engine.

While the engine reports busy, writes to the data and configuration registers are dropped without any error. This keeps the frame in flight intact. A write of the value 1 to a clear offset returns every register to its defaults: 9600 baud, one stop bit, parity off and data zero. The same write pulses the engine's reset. The hardware reset applies the same defaults.

Top module: `uart_tx_regfront`

## Requirements
- R1: While rst_i is high, eng_rst_o is 1. After the rst_i edge, the outputs are eng_rate_o = 9600, eng_stop_o = 1, eng_parity_o = 0 and rdata_o = 0, and the data register holds 0.
- R2: Offset 0x00 holds an 8-bit data register. An accepted write stores wdata_i[7:0]. A read returns the register zero-extended to 32 bits.
- R3: eng_start_o is 1 in a cycle only when that cycle carries req_i=1, we_i=1, addr_i=0x00 and eng_busy_i=0. It is driven combinationally within that same cycle.
- R4: eng_byte_o always equals wdata_i[7:0].
- R5: eng_busy_i is registered on every clock edge. A read of offset 0x08 returns in bit 0 the value eng_busy_i had in the cycle before the read request.
- R6: Offsets 0x0C, 0x10 and 0x14 hold the rate (17 bits), the parity enable (1 bit) and the stop count (2 bits). An accepted write keeps the low bits of wdata_i and drops the rest. The new value appears on eng_rate_o, eng_parity_o and eng_stop_o after the edge. Reads return the value zero-extended.
- R7: A write to 0x00, 0x0C, 0x10 or 0x14 while eng_busy_i=1 changes no register and raises no start pulse.
- R8: A write of exactly 1 to offset 0x24 restores the R1 defaults to the data and configuration registers, whether or not the engine is busy. It drives eng_rst_o high in that cycle. A write of any other value to 0x24 has no effect.
- R9: rdata_o updates only on the clock edge of an accepted read. It holds its value on writes, on idle cycles and on reads of offsets with no readable register, such as 0x04 and 0x24.
- R10: Writes to offsets with no writable register, including 0x08 and 0x18, change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous reset, active high |
| req_i | input | 1 | Bus access request |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 32 | Offset within the block |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Registered read data |
| eng_busy_i | input | 1 | Engine is sending a frame |
| eng_rate_o | output | 17 | Bit rate to the engine |
| eng_parity_o | output | 1 | Parity enable to the engine |
| eng_stop_o | output | 2 | Stop-bit count to the engine |
| eng_byte_o | output | 8 | Byte to transmit |
| eng_start_o | output | 1 | One-cycle start pulse |
| eng_rst_o | output | 1 | Engine reset |

## Verification
The start pulse, the engine reset and the byte output are combinational. They are due in the same cycle as the request, so the bench checks them one nanosecond after driving the inputs and before the next rising edge. Read data and the configuration outputs change on the rising edge that closes the request, and the bench samples them one nanosecond after that edge. The busy readback lags the engine by one further edge. The stimulus table therefore sets busy one row ahead of the read that expects to see it.

// File: rtl/uart_txf_pkg.sv
package uart_txf_pkg;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_DATA,
    SEL_BUSY,
    SEL_RATE,
    SEL_PAR,
    SEL_STOP,
    SEL_CLR
  } sel_e;

  localparam logic [31:0] OFF_DATA = 32'h0000_0000;
  localparam logic [31:0] OFF_BUSY = 32'h0000_0008;
  localparam logic [31:0] OFF_RATE = 32'h0000_000C;
  localparam logic [31:0] OFF_PAR  = 32'h0000_0010;
  localparam logic [31:0] OFF_STOP = 32'h0000_0014;
  localparam logic [31:0] OFF_CLR  = 32'h0000_0024;

  function automatic sel_e offset_sel(input logic [31:0] a);
    case (a)
      OFF_DATA: return SEL_DATA;
      OFF_BUSY: return SEL_BUSY;
      OFF_RATE: return SEL_RATE;
      OFF_PAR:  return SEL_PAR;
      OFF_STOP: return SEL_STOP;
      OFF_CLR:  return SEL_CLR;
      default:  return SEL_NONE;
    endcase
  endfunction

  function automatic logic sel_readable(input sel_e s);
    return (s != SEL_NONE) && (s != SEL_CLR);
  endfunction

  function automatic logic is_clear_word(input logic [31:0] w);
    return w == 32'd1;
  endfunction

endpackage

// File: rtl/uart_txf_decode.sv
module uart_txf_decode
  import uart_txf_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic          req_i,
  input  logic          we_i,
  input  logic [DW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          busy_i,
  output logic          rd_hit_o,
  output sel_e          rd_sel_o,
  output logic          wr_data_o,
  output logic          wr_rate_o,
  output logic          wr_par_o,
  output logic          wr_stop_o,
  output logic          soft_clr_o
);

  sel_e sel;
  logic wr_open;

  always_comb begin
    sel        = offset_sel(32'(addr_i));
    wr_open    = req_i && we_i && !busy_i;
    rd_hit_o   = req_i && !we_i && sel_readable(sel);
    rd_sel_o   = sel;
    wr_data_o  = wr_open && (sel == SEL_DATA);
    wr_rate_o  = wr_open && (sel == SEL_RATE);
    wr_par_o   = wr_open && (sel == SEL_PAR);
    wr_stop_o  = wr_open && (sel == SEL_STOP);
    soft_clr_o = req_i && we_i && (sel == SEL_CLR) && is_clear_word(32'(wdata_i));
  end

endmodule

// File: rtl/uart_txf_cfg.sv
module uart_txf_cfg #(
  parameter int DW     = 32,
  parameter int RATE_W = 17,
  parameter int STOP_W = 2,
  parameter int BYTE_W = 8,
  parameter logic [RATE_W-1:0] RATE_RST = '0,
  parameter logic [STOP_W-1:0] STOP_RST = '0
) (
  input  logic              clk_i,
  input  logic              rst_i,
  input  logic              clr_i,
  input  logic              busy_i,
  input  logic              wr_data_i,
  input  logic              wr_rate_i,
  input  logic              wr_par_i,
  input  logic              wr_stop_i,
  input  logic [DW-1:0]     wdata_i,
  output logic [BYTE_W-1:0] data_q,
  output logic [RATE_W-1:0] rate_q,
  output logic              par_q,
  output logic [STOP_W-1:0] stop_q,
  output logic              busy_q
);

  always_ff @(posedge clk_i) begin
    if (clr_i) begin
      data_q <= '0;
      rate_q <= RATE_RST;
      par_q  <= 1'b0;
      stop_q <= STOP_RST;
      busy_q <= 1'b0;
    end else begin
      busy_q <= busy_i;
      if (wr_data_i) data_q <= wdata_i[BYTE_W-1:0];
      if (wr_rate_i) rate_q <= wdata_i[RATE_W-1:0];
      if (wr_par_i)  par_q  <= wdata_i[0];
      if (wr_stop_i) stop_q <= wdata_i[STOP_W-1:0];
    end
  end

  assert_busy_lock_R7: assert property (@(posedge clk_i) disable iff (rst_i)
    (busy_i && !clr_i) |=> ($stable(data_q) && $stable(rate_q) && $stable(par_q) && $stable(stop_q)));

  assert_soft_defaults_R8: assert property (@(posedge clk_i) disable iff (rst_i)
    clr_i |=> (rate_q == RATE_RST && stop_q == STOP_RST && !par_q && data_q == '0));

  assert_busy_sample_R5: assert property (@(posedge clk_i) disable iff (rst_i)
    !clr_i |=> (busy_q == $past(busy_i)));

endmodule

// File: rtl/uart_txf_rdmux.sv
module uart_txf_rdmux
  import uart_txf_pkg::*;
#(
  parameter int DW     = 32,
  parameter int RATE_W = 17,
  parameter int STOP_W = 2,
  parameter int BYTE_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_i,
  input  logic              rd_hit_i,
  input  sel_e              rd_sel_i,
  input  logic [BYTE_W-1:0] data_i,
  input  logic              busy_i,
  input  logic [RATE_W-1:0] rate_i,
  input  logic              par_i,
  input  logic [STOP_W-1:0] stop_i,
  output logic [DW-1:0]     rdata_o
);

  logic [DW-1:0] rd_next;

  always_comb begin
    case (rd_sel_i)
      SEL_DATA: rd_next = DW'(data_i);
      SEL_BUSY: rd_next = DW'(busy_i);
      SEL_RATE: rd_next = DW'(rate_i);
      SEL_PAR:  rd_next = DW'(par_i);
      SEL_STOP: rd_next = DW'(stop_i);
      default:  rd_next = rdata_o;
    endcase
  end

  always_ff @(posedge clk_i) begin
    if (rst_i)         rdata_o <= '0;
    else if (rd_hit_i) rdata_o <= rd_next;
  end

  assert_read_hold_R9: assert property (@(posedge clk_i) disable iff (rst_i)
    !rd_hit_i |=> $stable(rdata_o));

endmodule

// File: rtl/uart_tx_regfront.sv
module uart_tx_regfront
  import uart_txf_pkg::*;
#(
  parameter int          DW       = 32,
  parameter int          RATE_W   = 17,
  parameter int          STOP_W   = 2,
  parameter int          BYTE_W   = 8,
  parameter int unsigned RATE_DEF = 9600,
  parameter int unsigned STOP_DEF = 1
) (
  input  logic              clk_i,
  input  logic              rst_i,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [DW-1:0]     addr_i,
  input  logic [DW-1:0]     wdata_i,
  output logic [DW-1:0]     rdata_o,
  input  logic              eng_busy_i,
  output logic [RATE_W-1:0] eng_rate_o,
  output logic              eng_parity_o,
  output logic [STOP_W-1:0] eng_stop_o,
  output logic [BYTE_W-1:0] eng_byte_o,
  output logic              eng_start_o,
  output logic              eng_rst_o
);

  localparam logic [RATE_W-1:0] RATE_RST = RATE_W'(RATE_DEF);
  localparam logic [STOP_W-1:0] STOP_RST = STOP_W'(STOP_DEF);

  logic              rd_hit, wr_data, wr_rate, wr_par, wr_stop, soft_clr, clr_all;
  sel_e              rd_sel;
  logic [BYTE_W-1:0] data_q;
  logic              busy_q;

  uart_txf_decode #(.DW(DW)) u_dec (
    .req_i(req_i), .we_i(we_i), .addr_i(addr_i), .wdata_i(wdata_i),
    .busy_i(eng_busy_i), .rd_hit_o(rd_hit), .rd_sel_o(rd_sel),
    .wr_data_o(wr_data), .wr_rate_o(wr_rate), .wr_par_o(wr_par),
    .wr_stop_o(wr_stop), .soft_clr_o(soft_clr)
  );

  assign clr_all = rst_i || soft_clr;

  uart_txf_cfg #(
    .DW(DW), .RATE_W(RATE_W), .STOP_W(STOP_W), .BYTE_W(BYTE_W),
    .RATE_RST(RATE_RST), .STOP_RST(STOP_RST)
  ) u_cfg (
    .clk_i(clk_i), .rst_i(rst_i), .clr_i(clr_all), .busy_i(eng_busy_i),
    .wr_data_i(wr_data), .wr_rate_i(wr_rate), .wr_par_i(wr_par),
    .wr_stop_i(wr_stop), .wdata_i(wdata_i), .data_q(data_q),
    .rate_q(eng_rate_o), .par_q(eng_parity_o), .stop_q(eng_stop_o),
    .busy_q(busy_q)
  );

  uart_txf_rdmux #(
    .DW(DW), .RATE_W(RATE_W), .STOP_W(STOP_W), .BYTE_W(BYTE_W)
  ) u_rd (
    .clk_i(clk_i), .rst_i(rst_i), .rd_hit_i(rd_hit), .rd_sel_i(rd_sel),
    .data_i(data_q), .busy_i(busy_q), .rate_i(eng_rate_o),
    .par_i(eng_parity_o), .stop_i(eng_stop_o), .rdata_o(rdata_o)
  );

  assign eng_byte_o  = wdata_i[BYTE_W-1:0];
  assign eng_start_o = wr_data;
  assign eng_rst_o   = clr_all;

  assert_start_gate_R3: assert property (@(posedge clk_i) disable iff (rst_i)
    eng_start_o |-> (req_i && we_i && !eng_busy_i && addr_i == DW'(OFF_DATA)));

  assert_start_data_R2: assert property (@(posedge clk_i) disable iff (rst_i)
    eng_start_o |=> (u_cfg.data_q == $past(wdata_i[BYTE_W-1:0])));

endmodule

// File: tb/uart_tx_regfront_tb.sv
module uart_tx_regfront_tb;

  logic        clk = 1'b0;
  logic        rst, req, we, busy;
  logic [31:0] addr, wdata, rdata;
  logic [16:0] rate;
  logic        par, start, erst;
  logic [1:0]  stop;
  logic [7:0]  byte_o;
  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  uart_tx_regfront u_dut (
    .clk_i(clk), .rst_i(rst), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .eng_busy_i(busy),
    .eng_rate_o(rate), .eng_parity_o(par), .eng_stop_o(stop),
    .eng_byte_o(byte_o), .eng_start_o(start), .eng_rst_o(erst)
  );

  typedef struct packed {
    logic        we;
    logic [7:0]  off;
    logic [31:0] wd;
    logic        busy;
    logic [31:0] rd;
    logic        st;
    logic [16:0] rate;
    logic        par;
    logic [1:0]  stop;
  } vec_t;

  localparam int NV = 17;
  localparam vec_t VEC [NV] = '{
    '{1'b1, 8'h0C, 32'h0001_C200, 1'b0, 32'h0,       1'b0, 17'h1C200, 1'b0, 2'd1}, // R6 rate
    '{1'b1, 8'h10, 32'hFFFF_FFFF, 1'b0, 32'h0,       1'b0, 17'h1C200, 1'b1, 2'd1}, // R6 parity truncation
    '{1'b1, 8'h14, 32'h0000_0006, 1'b0, 32'h0,       1'b0, 17'h1C200, 1'b1, 2'd2}, // R6 stop truncation
    '{1'b0, 8'h0C, 32'h0,         1'b0, 32'h1C200,   1'b0, 17'h1C200, 1'b1, 2'd2}, // R6 read
    '{1'b1, 8'h00, 32'h1234_56A5, 1'b0, 32'h1C200,   1'b1, 17'h1C200, 1'b1, 2'd2}, // R2 R3 R9
    '{1'b0, 8'h00, 32'h0,         1'b1, 32'hA5,      1'b0, 17'h1C200, 1'b1, 2'd2}, // R2 read
    '{1'b0, 8'h08, 32'h0,         1'b1, 32'h1,       1'b0, 17'h1C200, 1'b1, 2'd2}, // R5
    '{1'b1, 8'h00, 32'h0000_003C, 1'b1, 32'h1,       1'b0, 17'h1C200, 1'b1, 2'd2}, // R7 data
    '{1'b1, 8'h0C, 32'h0000_04B0, 1'b1, 32'h1,       1'b0, 17'h1C200, 1'b1, 2'd2}, // R7 rate
    '{1'b0, 8'h00, 32'h0,         1'b0, 32'hA5,      1'b0, 17'h1C200, 1'b1, 2'd2}, // R7 readback
    '{1'b0, 8'h14, 32'h0,         1'b0, 32'h2,       1'b0, 17'h1C200, 1'b1, 2'd2}, // R6 stop read
    '{1'b0, 8'h04, 32'h0,         1'b0, 32'h2,       1'b0, 17'h1C200, 1'b1, 2'd2}, // R9 hole
    '{1'b0, 8'h08, 32'h0,         1'b0, 32'h0,       1'b0, 17'h1C200, 1'b1, 2'd2}, // R5 idle
    '{1'b1, 8'h18, 32'h0000_FFFF, 1'b0, 32'h0,       1'b0, 17'h1C200, 1'b1, 2'd2}, // R10
    '{1'b1, 8'h24, 32'h0000_0002, 1'b0, 32'h0,       1'b0, 17'h1C200, 1'b1, 2'd2}, // R8 non-one
    '{1'b0, 8'h10, 32'h0,         1'b0, 32'h1,       1'b0, 17'h1C200, 1'b1, 2'd2}, // R6 parity read
    '{1'b1, 8'h08, 32'h0000_0001, 1'b0, 32'h1,       1'b0, 17'h1C200, 1'b1, 2'd2}  // R10 busy slot
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic drive(input logic r, input logic w, input logic [7:0] off,
                       input logic [31:0] wd, input logic b);
    @(negedge clk);
    req = r; we = w; addr = {24'h0, off}; wdata = wd; busy = b;
    #1;
  endtask

  task automatic edge_wait();
    @(posedge clk);
    #1;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    #(4 * 20000);
    failures++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    rst = 1'b1; req = 1'b0; we = 1'b0; addr = '0; wdata = '0; busy = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    chk("R1 eng_rst during reset", 32'(erst), 32'd1);
    @(negedge clk);
    rst = 1'b0;
    #1;
    chk("R1 rdata after reset", rdata, 32'd0);
    chk("R1 rate after reset", 32'(rate), 32'd9600);
    chk("R1 stop after reset", 32'(stop), 32'd1);
    chk("R1 parity after reset", 32'(par), 32'd0);
    chk("R1 eng_rst released", 32'(erst), 32'd0);

    for (int i = 0; i < NV; i++) begin
      vec_t v;
      v = VEC[i];
      drive(1'b1, v.we, v.off, v.wd, v.busy);
      chk("R3 start strobe", 32'(start), 32'(v.st));
      chk("R4 byte follows wdata", 32'(byte_o), 32'(v.wd[7:0]));
      chk("R8 no engine reset", 32'(erst), 32'd0);
      edge_wait();
      chk("R9 R2 R5 read data", rdata, v.rd);
      chk("R6 R7 R10 rate", 32'(rate), 32'(v.rate));
      chk("R6 R7 parity", 32'(par), 32'(v.par));
      chk("R6 R7 stop", 32'(stop), 32'(v.stop));
    end

    // R8: soft clear while busy
    drive(1'b1, 1'b1, 8'h24, 32'h1, 1'b1);
    chk("R8 eng_rst on clear", 32'(erst), 32'd1);
    chk("R3 no start on clear", 32'(start), 32'd0);
    edge_wait();
    chk("R8 rate default", 32'(rate), 32'd9600);
    chk("R8 stop default", 32'(stop), 32'd1);
    chk("R8 parity default", 32'(par), 32'd0);
    chk("R9 rdata held over clear", rdata, 32'd1);
    drive(1'b1, 1'b0, 8'h00, 32'h0, 1'b0);
    edge_wait();
    chk("R8 data cleared", rdata, 32'd0);

    // R3: a write without req raises no strobe and stores nothing
    drive(1'b0, 1'b1, 8'h00, 32'h0000_0077, 1'b0);
    chk("R3 no start without req", 32'(start), 32'd0);
    chk("R4 byte without req", 32'(byte_o), 32'h77);
    edge_wait();
    drive(1'b1, 1'b0, 8'h00, 32'h0, 1'b0);
    edge_wait();
    chk("R3 data unchanged without req", rdata, 32'd0);

    // R9: an idle cycle holds the read data
    drive(1'b1, 1'b0, 8'h0C, 32'h0, 1'b0);
    edge_wait();
    chk("R9 rate read", rdata, 32'd9600);
    drive(1'b0, 1'b0, 8'h00, 32'h0, 1'b0);
    edge_wait();
    chk("R9 idle hold", rdata, 32'd9600);

    // R1: hardware reset mid-run restores defaults
    drive(1'b1, 1'b1, 8'h14, 32'h3, 1'b0);
    edge_wait();
    chk("R6 stop written", 32'(stop), 32'd3);
    @(negedge clk);
    req = 1'b0; rst = 1'b1;
    #1;
    chk("R1 eng_rst follows rst", 32'(erst), 32'd1);
    edge_wait();
    chk("R1 stop restored", 32'(stop), 32'd1);
    chk("R1 rdata cleared", rdata, 32'd0);
    @(negedge clk);
    rst = 1'b0;
    repeat (2) @(posedge clk);
    finish_run();
  end

endmodule